// File: doc/BRIEF.md
# Dual-Width Free-Running Timer with Overflow Request

This block is a free-running up-counter built from two byte lanes. A configuration register selects at run time whether only the low lane counts (narrow mode) or the two lanes form one carry-linked 16-bit count (wide mode). When the count wraps at the selected width, a sticky overflow flag is set. The flag stays set until software clears it.

An enable bit in the configuration decides whether the flag raises a request. A priority bit routes that request to one of two outputs, high or low. Software can load either byte of the count at any time. A count-enable input freezes the counter while it is low.

The block has no data stream, so no valid/ready handshake is used. Every input is a single-cycle strobe or a level that is sampled at each rising clock edge. Every output is a plain registered or decoded level. Nothing at the block's edge can apply back-pressure.

Top module: `dual_mode_timer`

## Requirements
- R1: After the asynchronous active-low reset, both count bytes read 00h, the flag is 0, both request outputs are 0, and the configuration is all zero. That zero configuration selects narrow mode, request disabled and low priority.
- R2: In narrow mode (cfg_data bit 0 = 0), each cycle with `cnt_en` high adds one to the low byte, and the high byte keeps its value.
- R3: In narrow mode, a low-byte wrap from FFh to 00h sets the overflow flag at the same clock edge as the wrap.
- R4: In wide mode (cfg_data bit 0 = 1), a low-byte wrap carries one into the high byte without setting the flag. A wrap of the pair from FFFFh to 0000h sets the flag.
- R5: While `cnt_en` is low and no byte write occurs, both count bytes hold their values.
- R6: A `wr_lo` or `wr_hi` strobe loads `wr_data` into that byte at the next edge. No increment and no overflow happen in that cycle, and counting continues from the loaded value in the following cycle.
- R7: Once set, the flag stays set until `flag_clr` is pulsed. A `flag_clr` pulse in the same cycle as an overflow leaves the flag set.
- R8: With the request enable bit (cfg_data bit 1) at 0, both request outputs stay 0 whatever the state of the flag.
- R9: With the request enabled, a set flag drives `irq_hi` when the priority bit (cfg_data bit 2) is 1, and drives `irq_lo` when it is 0. The two outputs are never high together.
- R10: A `cfg_wr` strobe loads all three configuration bits from `cfg_data` at the next edge, and the new width takes effect from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_en | input | 1 | Count enable level |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_data | input | 3 | bit 0 wide mode, bit 1 request enable, bit 2 high priority |
| wr_lo | input | 1 | Load strobe for the low count byte |
| wr_hi | input | 1 | Load strobe for the high count byte |
| wr_data | input | 8 | Byte value for a count load |
| flag_clr | input | 1 | Overflow flag clear strobe |
| count_lo | output | 8 | Low count byte |
| count_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq_hi | output | 1 | High-priority request |
| irq_lo | output | 1 | Low-priority request |

## Verification
Two pairs of events can fall in the same cycle: a software flag clear with a fresh wrap, and a byte load with a pending increment at FFh. The bench provokes the first by preloading FFh with the flag already set, then raising `flag_clr` and `cnt_en` at the same time; the flag must read 1 and the low byte 00h afterwards. It provokes the second by loading the low byte while the counter runs at FFh; the flag must stay 0, the byte must read the loaded value, and the next cycle must show that value plus one.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic hi_pri;
    logic req_on;
    logic wide;
  } dmt_cfg_t;
endpackage

// File: rtl/dmt_lanes.sv
module dmt_lanes #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cnt_en,
  input  logic                         wide,
  input  logic [LANES-1:0]             wr_lane,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [LANES-1:0][BYTE_W-1:0] cnt,
  output logic                         wrap
);
  logic             step;
  logic [LANES-1:0] full;
  logic [LANES-1:0] carry;

  assign step = cnt_en & ~(|wr_lane);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign full[g] = &cnt[g];
    if (g == 0) begin : g_first
      assign carry[g] = step;
    end else begin : g_rest
      assign carry[g] = carry[g-1] & full[g-1] & wide;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt[g] <= '0;
      else if (wr_lane[g]) cnt[g] <= wr_data;
      else if (carry[g])   cnt[g] <= cnt[g] + 1'b1;
    end
  end

  assign wrap = step & (wide ? (&full) : full[0]);

  // R5: frozen when idle
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && wr_lane == '0) |=> $stable(cnt));
  // R2: upper lane untouched in narrow mode
  assert_narrow_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !wr_lane[LANES-1]) |=> $stable(cnt[LANES-1]));
  // R6: load takes the written byte
  assert_load_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lane[0] |=> cnt[0] == $past(wr_data));
endmodule

// File: rtl/dmt_flag.sv
module dmt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R7: set wins over clear, clear alone drops the flag
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/dmt_route.sv
module dmt_route (
  input  logic clk,
  input  logic rst_n,
  input  logic flag,
  input  logic req_on,
  input  logic hi_pri,
  output logic irq_hi,
  output logic irq_lo
);
  logic live;
  assign live   = flag & req_on;
  assign irq_hi = live & hi_pri;
  assign irq_lo = live & ~hi_pri;

  // R9: never both requests
  assert_one_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_hi, irq_lo}));
  // R8: no request without enable
  assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_on |-> !(irq_hi || irq_lo));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_data,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              flag_clr,
  output logic [BYTE_W-1:0] count_lo,
  output logic [BYTE_W-1:0] count_hi,
  output logic              ovf_flag,
  output logic              irq_hi,
  output logic              irq_lo
);
  import dmt_pkg::*;

  dmt_cfg_t                          cfg;
  logic [LANES-1:0][BYTE_W-1:0]      cnt;
  logic                              wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg <= '0;
    else if (cfg_wr) cfg <= dmt_cfg_t'(cfg_data);
  end

  dmt_lanes #(.LANES(LANES), .BYTE_W(BYTE_W)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .wide    (cfg.wide),
    .wr_lane ({wr_hi, wr_lo}),
    .wr_data (wr_data),
    .cnt     (cnt),
    .wrap    (wrap)
  );

  dmt_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (wrap),
    .clr   (flag_clr),
    .flag  (ovf_flag)
  );

  dmt_route u_route (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag   (ovf_flag),
    .req_on (cfg.req_on),
    .hi_pri (cfg.hi_pri),
    .irq_hi (irq_hi),
    .irq_lo (irq_lo)
  );

  assign count_lo = cnt[0];
  assign count_hi = cnt[LANES-1];

  // R3: narrow wrap raises the flag
  assert_narrow_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.wide && cnt_en && !wr_lo && !wr_hi && (&count_lo)) |=> (ovf_flag && count_lo == '0));
  // R4: wide carry without flag unless full pair
  assert_wide_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.wide && cnt_en && !wr_lo && !wr_hi && (&count_lo) && !(&count_hi))
      |=> (count_hi == $past(count_hi) + 1'b1));
  // R6: write cycle never overflows
  assert_no_ovf_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_lo || wr_hi) && !ovf_flag) |=> !ovf_flag);
endmodule

// File: tb/tb_dual_mode_timer.sv
`timescale 1ns/1ps
module tb_dual_mode_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0, cfg_wr = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0, flag_clr = 1'b0;
  logic [2:0] cfg_data = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count_lo, count_hi;
  logic       ovf_flag, irq_hi, irq_lo;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dual_mode_timer dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .flag_clr(flag_clr),
    .count_lo(count_lo), .count_hi(count_hi), .ovf_flag(ovf_flag),
    .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  typedef struct packed {
    logic       wide;
    logic [7:0] hi, lo, n, ehi, elo;
    logic       ef;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 8'h12, 8'h00, 8'd5,  8'h12, 8'h05, 1'b0}, // R2 plain count
    '{1'b0, 8'h34, 8'hFE, 8'd1,  8'h34, 8'hFF, 1'b0}, // R3 one short of wrap
    '{1'b0, 8'h34, 8'hFE, 8'd2,  8'h34, 8'h00, 1'b1}, // R3 wrap
    '{1'b0, 8'h00, 8'hF0, 8'd32, 8'h00, 8'h10, 1'b1}, // R3 wrap and beyond
    '{1'b1, 8'h00, 8'hFF, 8'd1,  8'h01, 8'h00, 1'b0}, // R4 carry, no flag
    '{1'b1, 8'hFF, 8'hFE, 8'd2,  8'h00, 8'h00, 1'b1}, // R4 pair wrap
    '{1'b1, 8'h12, 8'hF0, 8'd20, 8'h13, 8'h04, 1'b0}, // R4 carry mid-run
    '{1'b1, 8'hFF, 8'hFF, 8'd3,  8'h00, 8'h02, 1'b1}  // R4 wrap and beyond
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_cfg(logic [2:0] v);
    cfg_data = v; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
  endtask

  task automatic load(logic [7:0] h, logic [7:0] l);
    wr_data = h; wr_hi = 1'b1; tick(); wr_hi = 1'b0;
    wr_data = l; wr_lo = 1'b1; tick(); wr_lo = 1'b0;
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
  endtask

  task automatic run(int n);
    cnt_en = 1'b1;
    for (int i = 0; i < n; i++) tick();
    cnt_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    // R1: reset state
    check("R1 lo", count_lo, 8'h00);
    check("R1 hi", count_hi, 8'h00);
    check("R1 flag", ovf_flag, 1'b0);
    check("R1 irqs", {irq_hi, irq_lo}, 2'b00);
    rst_n = 1'b1;
    tick();
    // R1: narrow mode by default, no cfg write
    load(8'h07, 8'hFF);
    run(1);
    check("R1 default narrow hi", count_hi, 8'h07);
    check("R1 default narrow flag", ovf_flag, 1'b1);
    clear_flag();

    // table walk: R2 R3 R4 R10
    foreach (VECS[k]) begin
      set_cfg({2'b00, VECS[k].wide});
      load(VECS[k].hi, VECS[k].lo);
      clear_flag();
      run(int'(VECS[k].n));
      check($sformatf("R2/R3/R4 vec%0d lo", k), count_lo, VECS[k].elo);
      check($sformatf("R2/R3/R4 vec%0d hi", k), count_hi, VECS[k].ehi);
      check($sformatf("R2/R3/R4 vec%0d flag", k), ovf_flag, VECS[k].ef);
    end

    // R5: hold while disabled
    set_cfg(3'b001);
    load(8'hAB, 8'hCD);
    repeat (5) tick();
    check("R5 lo hold", count_lo, 8'hCD);
    check("R5 hi hold", count_hi, 8'hAB);

    // R6: write while running at FFh, narrow mode
    set_cfg(3'b000);
    load(8'h00, 8'hFF);
    clear_flag();
    cnt_en = 1'b1; wr_data = 8'h40; wr_lo = 1'b1;
    tick();
    wr_lo = 1'b0;
    check("R6 loaded", count_lo, 8'h40);
    check("R6 no overflow on write", ovf_flag, 1'b0);
    tick();
    cnt_en = 1'b0;
    check("R6 resume", count_lo, 8'h41);

    // R7: sticky flag, clear, and clear colliding with wrap
    load(8'h00, 8'hFF);
    run(1);
    repeat (4) tick();
    check("R7 sticky", ovf_flag, 1'b1);
    clear_flag();
    check("R7 cleared", ovf_flag, 1'b0);
    run(255);
    check("R7 pre-wrap flag", ovf_flag, 1'b0);
    check("R7 pre-wrap lo", count_lo, 8'hFF);
    run(1);
    load(8'h00, 8'hFF);
    cnt_en = 1'b1; flag_clr = 1'b1;
    tick();
    cnt_en = 1'b0; flag_clr = 1'b0;
    check("R7 clear vs wrap flag", ovf_flag, 1'b1);
    check("R7 clear vs wrap lo", count_lo, 8'h00);

    // R8: flag set but requests disabled
    set_cfg(3'b100);
    check("R8 gated", {irq_hi, irq_lo}, 2'b00);
    // R9: priority routing
    set_cfg(3'b110);
    check("R9 high route", {irq_hi, irq_lo}, 2'b10);
    set_cfg(3'b010);
    check("R9 low route", {irq_hi, irq_lo}, 2'b01);
    clear_flag();
    check("R9 drop on clear", {irq_hi, irq_lo}, 2'b00);

    // R10: width change takes effect at once
    load(8'h05, 8'hFF);
    set_cfg(3'b001);
    run(1);
    check("R10 wide carry", count_hi, 8'h06);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule